// File: doc/BRIEF.md
# Reference-Lock Control State Machine

This block decides the timing mode of a digital PLL that can track any one of several candidate reference clocks. It watches per-reference valid flags, a phase-lock indication from the loop and a one-second strobe. From these it picks a reference, opens a timed acquisition window and declares lock only after phase lock has been held for a minimum number of seconds. A reference that cannot be locked inside the window is disqualified and the controller fails over to the next one. In revertive mode it moves to a reference of higher priority when one becomes usable.

The controller reports its state as a 3-bit code, which reference it has chosen, and the filtered valid flags. A sticky change flag can drive an interrupt, and a sticky alarm marks an acquisition timeout. Software can pin the state through a force request. Priority is by index, and index 0 is the highest.

Top module: `ref_lock_ctrl`

## Requirements
- R1: After reset, state_o is free-run (3'b001), sel_valid_o, lock_alarm_o, state_chg_o and irq_o are 0. The remaining state codes are holdover 3'b010, locked 3'b100, prelocked-2 3'b101, prelocked 3'b110 and loss-of-lock 3'b111.
- R2: In free-run, on the first clock edge with any filtered valid bit set, the state becomes prelocked and sel_o becomes the lowest set index of ref_valid_o.
- R3: In prelocked or prelocked-2, the state becomes locked on the LOCK_SEC-th strobe counted while phase_lock_i stays high. A low phase_lock_i in any cycle restarts the count.
- R4: If the acquisition window reaches timeout_sec_i strobes without lock, lock_alarm_o is set and stays set until alarm_clr_i. The chosen reference's bit of ref_valid_o is forced to 0 until its ref_valid_i bit goes low, and sel_valid_o drops to 0.
- R5: After a timeout, if another reference is still valid, the next clock edge selects the lowest valid index with sel_valid_o = 1 and restarts a full window in the same state.
- R6: In a prelocked state with no valid reference and no selection, NOREF_SEC consecutive strobes return the state to free-run.
- R7: With revert_en_i = 1, a valid reference of lower index than sel_o in a prelocked state is selected on the next edge and the window restarts. With revert_en_i = 0 the selection is kept. In locked, the same event moves the state to prelocked-2 on that reference.
- R8: In locked, loss of the chosen reference or of phase_lock_i moves the state to loss-of-lock. Loss-of-lock moves on the next edge to prelocked-2 on the lowest valid index if one exists, and to holdover otherwise.
- R9: In holdover, the first valid reference moves the state to prelocked-2 with that reference selected.
- R10: While force_en_i is high with a legal code on force_state_i, state_o takes that code on the next edge and holds it, overriding every automatic transition.
- R11: Every change of state_o sets state_chg_o, which stays set until chg_clr_i. irq_o is state_chg_o gated by irq_en_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_valid_i | input | N_REF | Raw per-reference valid flags |
| sec_tick_i | input | 1 | Single-cycle one-second strobe |
| phase_lock_i | input | 1 | Phase lock indication from the loop |
| timeout_sec_i | input | TMR_W | Acquisition window length in seconds |
| revert_en_i | input | 1 | Revertive selection enable |
| force_en_i | input | 1 | Force-state request |
| force_state_i | input | 3 | State code to force |
| irq_en_i | input | 1 | Interrupt enable for the change flag |
| chg_clr_i | input | 1 | Clear for state_chg_o |
| alarm_clr_i | input | 1 | Clear for lock_alarm_o |
| state_o | output | 3 | Current state code |
| sel_o | output | $clog2(N_REF) | Selected reference index |
| sel_valid_o | output | 1 | A reference is currently selected |
| ref_valid_o | output | N_REF | Valid flags with timed-out references removed |
| lock_alarm_o | output | 1 | Sticky acquisition-timeout alarm |
| state_chg_o | output | 1 | Sticky state-change flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with four references, LOCK_SEC = 2 and NOREF_SEC = 2, and drives timeout_sec_i to 5. It also raises the one-second strobe only when a scenario needs it. Short windows like these bring the timeout, disqualification, failover, free-run fallback and revertive paths within a few dozen cycles each. Random non-zero valid patterns exercise the priority pick from free-run.

// File: rtl/ref_lock_pkg.sv
package ref_lock_pkg;

  typedef enum logic [2:0] {
    ST_FREE   = 3'b001,
    ST_HOLD   = 3'b010,
    ST_LOCKED = 3'b100,
    ST_PRE2   = 3'b101,
    ST_PRE    = 3'b110,
    ST_LOL    = 3'b111
  } lk_state_e;

  function automatic logic is_legal(input logic [2:0] code);
    return (code != 3'b000) && (code != 3'b011);
  endfunction

  function automatic logic is_pre(input logic [2:0] code);
    return (code == ST_PRE) || (code == ST_PRE2);
  endfunction

endpackage

// File: rtl/ref_prio_pick.sv
module ref_prio_pick #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/ref_qual.sv
module ref_qual #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  raw_i,
  input  logic          fail_set_i,
  input  logic [IW-1:0] fail_idx_i,
  output logic [N-1:0]  eff_o
);
  logic [N-1:0] fail_q;

  for (genvar g = 0; g < N; g++) begin : g_bit
    // disqualification lasts until the raw flag drops
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                     fail_q[g] <= 1'b0;
      else if (!raw_i[g])                              fail_q[g] <= 1'b0;
      else if (fail_set_i && (fail_idx_i == IW'(g)))   fail_q[g] <= 1'b1;
    end
  end

  assign eff_o = raw_i & ~fail_q;
endmodule

// File: rtl/sec_cnt.sv
module sec_cnt #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_o <= '0;
    else if (clr_i)                      cnt_o <= '0;
    else if (inc_i && (cnt_o != '1))     cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/ref_lock_ctrl.sv
module ref_lock_ctrl
  import ref_lock_pkg::*;
#(
  parameter int N_REF     = 4,
  parameter int TMR_W     = 16,
  parameter int LOCK_SEC  = 2,
  parameter int NOREF_SEC = 2,
  localparam int IW = $clog2(N_REF),
  localparam int HW = $clog2(LOCK_SEC + 1),
  localparam int NW = $clog2(NOREF_SEC + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_REF-1:0] ref_valid_i,
  input  logic             sec_tick_i,
  input  logic             phase_lock_i,
  input  logic [TMR_W-1:0] timeout_sec_i,
  input  logic             revert_en_i,
  input  logic             force_en_i,
  input  logic [2:0]       force_state_i,
  input  logic             irq_en_i,
  input  logic             chg_clr_i,
  input  logic             alarm_clr_i,
  output logic [2:0]       state_o,
  output logic [IW-1:0]    sel_o,
  output logic             sel_valid_o,
  output logic [N_REF-1:0] ref_valid_o,
  output logic             lock_alarm_o,
  output logic             state_chg_o,
  output logic             irq_o
);
  lk_state_e      state_q, state_d;
  logic [IW-1:0]  sel_q, sel_d;
  logic           has_q, has_d;
  logic           restart, fail_set;
  logic           alarm_q, chg_q;

  logic [N_REF-1:0] eff;
  logic             any;
  logic [IW-1:0]    best;

  logic [TMR_W-1:0] win_cnt;
  logic [HW-1:0]    hold_cnt;
  logic [NW-1:0]    noref_cnt;

  logic in_pre, sel_ok, higher, hold_done, win_done, noref_done, chg_now;

  ref_qual #(.N(N_REF)) u_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .raw_i      (ref_valid_i),
    .fail_set_i (fail_set),
    .fail_idx_i (sel_q),
    .eff_o      (eff)
  );

  ref_prio_pick #(.N(N_REF)) u_pick (
    .req_i (eff),
    .any_o (any),
    .idx_o (best)
  );

  assign in_pre  = is_pre(state_q);
  assign sel_ok  = has_q && eff[sel_q];
  assign higher  = revert_en_i && has_q && any && (best < sel_q);
  assign chg_now = (state_d != state_q);

  assign hold_done  = sec_tick_i && phase_lock_i && (hold_cnt == HW'(LOCK_SEC - 1));
  assign win_done   = sec_tick_i &&
                      (({1'b0, win_cnt} + 1'b1) >= {1'b0, timeout_sec_i});
  assign noref_done = sec_tick_i && (noref_cnt == NW'(NOREF_SEC - 1));

  sec_cnt #(.W(TMR_W)) u_win (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart || !in_pre || chg_now),
    .inc_i  (in_pre && sel_ok && sec_tick_i),
    .cnt_o  (win_cnt)
  );

  sec_cnt #(.W(HW)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart || !in_pre || chg_now || !phase_lock_i),
    .inc_i  (in_pre && sel_ok && sec_tick_i),
    .cnt_o  (hold_cnt)
  );

  sec_cnt #(.W(NW)) u_noref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (restart || !in_pre || any || sel_ok),
    .inc_i  (in_pre && sec_tick_i),
    .cnt_o  (noref_cnt)
  );

  always_comb begin
    state_d  = state_q;
    sel_d    = sel_q;
    has_d    = has_q;
    restart  = 1'b0;
    fail_set = 1'b0;
    unique case (state_q)
      ST_FREE: begin
        if (any) begin
          state_d = ST_PRE;
          sel_d   = best;
          has_d   = 1'b1;
          restart = 1'b1;
        end
      end
      ST_PRE, ST_PRE2: begin
        if (sel_ok) begin
          if (higher) begin
            sel_d   = best;
            restart = 1'b1;
          end else if (hold_done) begin
            state_d = ST_LOCKED;
          end else if (win_done) begin
            fail_set = 1'b1;
            has_d    = 1'b0;
          end
        end else if (any) begin
          sel_d   = best;
          has_d   = 1'b1;
          restart = 1'b1;
        end else begin
          has_d = 1'b0;
          if (noref_done) state_d = ST_FREE;
        end
      end
      ST_LOCKED: begin
        if (!sel_ok || !phase_lock_i) begin
          state_d = ST_LOL;
        end else if (higher) begin
          state_d = ST_PRE2;
          sel_d   = best;
          restart = 1'b1;
        end
      end
      ST_LOL: begin
        if (any) begin
          state_d = ST_PRE2;
          sel_d   = best;
          has_d   = 1'b1;
          restart = 1'b1;
        end else begin
          state_d = ST_HOLD;
          has_d   = 1'b0;
        end
      end
      ST_HOLD: begin
        if (any) begin
          state_d = ST_PRE2;
          sel_d   = best;
          has_d   = 1'b1;
          restart = 1'b1;
        end
      end
      default: begin
        state_d = ST_FREE;
        has_d   = 1'b0;
      end
    endcase

    // software override wins over every automatic move
    if (force_en_i && is_legal(force_state_i)) begin
      state_d  = lk_state_e'(force_state_i);
      sel_d    = sel_q;
      has_d    = has_q;
      restart  = 1'b1;
      fail_set = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FREE;
      sel_q   <= '0;
      has_q   <= 1'b0;
      alarm_q <= 1'b0;
      chg_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      sel_q   <= sel_d;
      has_q   <= has_d;
      if (fail_set)         alarm_q <= 1'b1;
      else if (alarm_clr_i) alarm_q <= 1'b0;
      if (chg_now)          chg_q   <= 1'b1;
      else if (chg_clr_i)   chg_q   <= 1'b0;
    end
  end

  assign state_o      = state_q;
  assign sel_o        = sel_q;
  assign sel_valid_o  = has_q;
  assign ref_valid_o  = eff;
  assign lock_alarm_o = alarm_q;
  assign state_chg_o  = chg_q;
  assign irq_o        = chg_q && irq_en_i;

endmodule

// File: rtl/ref_lock_chk.sv
module ref_lock_chk
  import ref_lock_pkg::*;
#(
  parameter int N_REF = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_REF-1:0] ref_valid_o,
  input logic             sec_tick_i,
  input logic             phase_lock_i,
  input logic             force_en_i,
  input logic [2:0]       force_state_i,
  input logic             alarm_clr_i,
  input logic [2:0]       state_o,
  input logic             lock_alarm_o,
  input logic             state_chg_o,
  input logic             irq_o
);
  p_legal_state_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_legal(state_o));

  p_free_exit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_FREE && (|ref_valid_o) && !force_en_i) |=> (state_o == ST_PRE));

  p_lock_qualified_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_pre(state_o) && !force_en_i) |=>
      ((state_o != ST_LOCKED) || ($past(phase_lock_i) && $past(sec_tick_i))));

  p_alarm_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_alarm_o && !alarm_clr_i) |=> lock_alarm_o);

  p_lol_exit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_LOL && !force_en_i) |=> (state_o == ST_HOLD || state_o == ST_PRE2));

  p_force_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_en_i && is_legal(force_state_i)) |=> (state_o == $past(force_state_i)));

  p_chg_flag_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(state_o) |-> state_chg_o);

  p_irq_source_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> state_chg_o);
endmodule

bind ref_lock_ctrl ref_lock_chk #(.N_REF(N_REF)) u_chk (.*);

// File: tb/ref_lock_ctrl_test.sv
`timescale 1ns/1ps
module ref_lock_ctrl_test;
  localparam int N = 4;
  localparam int IW = 2;
  localparam int TW = 8;
  localparam int TMO = 5;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [N-1:0] valid = '0;
  logic tick = 1'b0, plock = 1'b0, rev = 1'b0, fen = 1'b0, irq_en = 1'b0;
  logic chg_clr = 1'b0, alm_clr = 1'b0;
  logic [2:0] fstate = 3'b000;
  logic [TW-1:0] tmo = TW'(TMO);
  logic [2:0] state;
  logic [IW-1:0] sel;
  logic sel_v, alarm, chg, irq;
  logic [N-1:0] vout;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  ref_lock_ctrl #(.N_REF(N), .TMR_W(TW), .LOCK_SEC(2), .NOREF_SEC(2)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ref_valid_i(valid), .sec_tick_i(tick),
    .phase_lock_i(plock), .timeout_sec_i(tmo), .revert_en_i(rev),
    .force_en_i(fen), .force_state_i(fstate), .irq_en_i(irq_en),
    .chg_clr_i(chg_clr), .alarm_clr_i(alm_clr), .state_o(state), .sel_o(sel),
    .sel_valid_o(sel_v), .ref_valid_o(vout), .lock_alarm_o(alarm),
    .state_chg_o(chg), .irq_o(irq));

  function automatic int lowest(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic sec();
    tick = 1'b1; step(); tick = 1'b0;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; valid = '0; plock = 0; rev = 0; fen = 0; irq_en = 0;
    step(2); rst_ni = 1'b1; step();
  endtask

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic clear_flags();
    chg_clr = 1; alm_clr = 1; step(); chg_clr = 0; alm_clr = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1eaf));
    do_reset();
    chk("R1 state", state, 3'b001);
    chk("R1 sel_valid", sel_v, 0);
    chk("R1 alarm", alarm, 0);
    chk("R1 chg", chg, 0);
    chk("R1 irq", irq, 0);

    // free-run exit, change flag and irq
    irq_en = 1; valid = 4'b0101; step();
    chk("R2 state", state, 3'b110);
    chk("R2 sel", sel, 0);
    chk("R11 chg", chg, 1);
    chk("R11 irq", irq, 1);
    irq_en = 0; step();
    chk("R11 irq gated", irq, 0);
    clear_flags();
    chk("R11 chg clr", chg, 0);

    // lock qualification with a dropout
    plock = 1; sec();
    plock = 0; step(); plock = 1; sec();
    chk("R3 after dropout", state, 3'b110);
    sec();
    chk("R3 locked", state, 3'b100);

    // loss of chosen reference while locked
    plock = 0; valid = 4'b0100; step();
    chk("R8 lol", state, 3'b111);
    step();
    chk("R8 pre2", state, 3'b101);
    chk("R8 sel", sel, 2);

    // timeout with no alternate
    repeat (TMO - 1) sec();
    chk("R4 no early alarm", alarm, 0);
    sec();
    chk("R4 alarm", alarm, 1);
    chk("R4 masked", vout, 0);
    chk("R4 sel_valid", sel_v, 0);
    sec();
    chk("R6 one sec", state, 3'b101);
    sec();
    chk("R6 free", state, 3'b001);
    step(3);
    chk("R4 mask holds", vout, 0);
    chk("R4 stays free", state, 3'b001);
    step(3);
    chk("R4 alarm sticky", alarm, 1);
    valid = 4'b0000; step(); valid = 4'b0100; step();
    chk("R4 requalified", vout, 4'b0100);
    step();
    chk("R2 reentry", state, 3'b110);

    // failover to alternate
    do_reset();
    valid = 4'b1100; step();
    chk("R2 sel 2", sel, 2);
    repeat (TMO) sec();
    chk("R4 alarm 2", alarm, 1);
    step();
    chk("R5 sel", sel, 3);
    chk("R5 sel_valid", sel_v, 1);
    chk("R5 state", state, 3'b110);
    clear_flags();
    repeat (TMO - 1) sec();
    chk("R5 window restarted", alarm, 0);
    sec();
    chk("R5 second timeout", alarm, 1);

    // revertive behaviour
    do_reset();
    valid = 4'b1000; step();
    valid = 4'b1010; step(2);
    chk("R7 non-revertive keeps", sel, 3);
    rev = 1; step();
    chk("R7 revert sel", sel, 1);
    chk("R7 revert state", state, 3'b110);
    plock = 1; sec(); sec();
    chk("R3 locked on 1", state, 3'b100);
    valid = 4'b1011; step();
    chk("R7 locked revert", state, 3'b101);
    chk("R7 locked revert sel", sel, 0);

    // holdover entry and exit
    do_reset();
    valid = 4'b0001; step(); plock = 1; sec(); sec();
    chk("R3 locked on 0", state, 3'b100);
    valid = 4'b0000; plock = 0; step();
    chk("R8 lol 2", state, 3'b111);
    step();
    chk("R8 hold", state, 3'b010);
    step(4);
    chk("R9 hold stays", state, 3'b010);
    valid = 4'b0010; step();
    chk("R9 pre2", state, 3'b101);
    chk("R9 sel", sel, 1);

    // force override
    fen = 1; fstate = 3'b010; step();
    chk("R10 forced", state, 3'b010);
    step(3);
    chk("R10 held", state, 3'b010);
    fstate = 3'b100; step();
    chk("R10 forced lock", state, 3'b100);
    fen = 0; fstate = 3'b000; step();
    chk("R10 release", state, 3'b111);

    // random priority picks out of free-run
    for (int k = 0; k < 24; k++) begin
      logic [N-1:0] v;
      do_reset();
      do v = N'($urandom); while (v == '0);
      valid = v; step();
      chk("R2 rand state", state, 3'b110);
      chk("R2 rand sel", sel, lowest(v));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule